// File: doc/BRIEF.md
# External Interrupt Pin Edge Controller

This block turns a small set of external interrupt pins into latched request flags and one combined interrupt line. Each pin is first brought into the clock domain by a multi-stage synchroniser. It then passes through a pin-function gate: while the channel's function-enable bit is 0, the edge detector sees a constant high level instead of the pin. A per-channel edge-select bit picks falling or rising edges. A detected edge sets the channel's request flag. The flag holds until software writes 0 to it.

Because the detector watches the gated level and not the raw pin, rewriting the function-enable bit can produce an edge by itself. The block keeps this behaviour on purpose. It also has a second rule for the same situation: a flag-clear write placed in the access slot directly after a mode-register write is dropped. Software must therefore mask the channel, rewrite the mode register, leave one slot free, and then clear the flag.

Each channel also has an interrupt-enable bit. The combined output is raised when any flag is set together with its enable bit. Flags still latch while their enable bit is 0.

Top module: `ext_irq_edge_ctrl`

## Requirements
- R1: After reset every mode, edge-select, enable and flag bit is 0, and `irq_o` is 0.
- R2: A write takes effect at the clock edge that samples `wr_en_i` high. Bit i of a write refers to channel i+1. The register addresses are: 0 = function enable, 1 = edge select, 2 = interrupt enable, 3 = request flags. Writing 1 to a flag bit has no effect.
- R3: With function enable 1 and edge select 0, a falling pin level sets the flag. The flag is visible after the second clock edge following the edge that first samples the new pin level.
- R4: With function enable 1 and edge select 1, a rising pin level sets the flag, with the same latency as R3. An edge of the opposite polarity sets nothing.
- R5: If the function-enable bit goes from 0 to 1 while the pin is low, a channel with edge select 0 sets its flag. A channel with edge select 1 does not.
- R6: If the function-enable bit goes from 1 to 0 while the pin is low, a channel with edge select 1 sets its flag. A channel with edge select 0 does not.
- R7: If the pin is high while the function-enable bit is rewritten, no flag is set.
- R8: A set flag stays set until a write of 0 to it takes effect. That write clears it at the edge that samples the write.
- R9: A flag-clear write sampled at the edge directly after a function-enable write is ignored. A clear two or more slots after that write takes effect.
- R10: `irq_o` is the OR over all channels of (flag AND enable). Flags still set while their enable is 0.
- R11: When a flag-set event and an effective clear fall on the same edge, the flag ends up set.
- R12: While a channel's function-enable bit is 0, pin toggles never set its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pin_i | input | NUM_CH | Asynchronous external interrupt pins, bit i is channel i+1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | NUM_CH | Write data, one bit per channel |
| req_flag_o | output | NUM_CH | Latched request flags |
| irq_o | output | 1 | Combined enabled interrupt request |

## Verification
The bench builds the block with its default parameters: three channels and a two-stage synchroniser. At that size the whole space of mode-rewrite cases can be swept. Each case varies the channel, the edge select, the pin level and the direction of the enable change, and every case's expected flag is derived from the R5 to R7 rules. With three channels, all eight interrupt-enable masks can also be tried against two different flag patterns. The fixed two-stage latency lets the bench land a clear on exactly the same edge as a set, and put a clear in the first and then the second slot after a mode write.

// File: rtl/eirq_pkg.sv
// Package: shared register-select encoding for the external interrupt
// edge controller. Assumes a two-bit register address.
package eirq_pkg;

    typedef enum logic [1:0] {
        REG_FUNC_EN = 2'd0,
        REG_EDGE    = 2'd1,
        REG_IEN     = 2'd2,
        REG_FLAG    = 2'd3
    } eirq_reg_e;

endpackage

// File: rtl/eirq_sync.sv
// Module: eirq_sync
// Brings one asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes the input is a slow level, not a data bus. The
// chain resets to RST_VAL so an idle-high pin reads high out of reset.
module eirq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/eirq_regs.sv
// Module: eirq_regs
// Holds the function-enable, edge-select and interrupt-enable registers,
// and turns flag writes into per-channel clear requests. A flag write in
// the slot right after a function-enable write is suppressed. Assumes one
// write per clock at most.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    output logic [NUM_CH-1:0] func_en_o,
    output logic [NUM_CH-1:0] rise_sel_o,
    output logic [NUM_CH-1:0] ien_o,
    output logic [NUM_CH-1:0] clr_req_o
);

    eirq_reg_e         sel;
    logic              func_wr;
    logic              func_wr_q;
    logic [NUM_CH-1:0] func_en_q;
    logic [NUM_CH-1:0] rise_sel_q;
    logic [NUM_CH-1:0] ien_q;

    assign sel     = eirq_reg_e'(wr_addr_i);
    assign func_wr = wr_en_i && (sel == REG_FUNC_EN);

    // Update the control registers from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_en_q  <= '0;
            rise_sel_q <= '0;
            ien_q      <= '0;
        end else if (wr_en_i) begin
            case (sel)
                REG_FUNC_EN: func_en_q  <= wr_data_i;
                REG_EDGE:    rise_sel_q <= wr_data_i;
                REG_IEN:     ien_q      <= wr_data_i;
                default:     ;
            endcase
        end
    end

    // Remember that the previous slot held a function-enable write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_wr_q <= 1'b0;
        end else begin
            func_wr_q <= func_wr;
        end
    end

    // Decode flag writes of 0 into clear requests, except right after a mode write.
    always_comb begin
        clr_req_o = '0;
        if (wr_en_i && (sel == REG_FLAG) && !func_wr_q) begin
            clr_req_o = ~wr_data_i;
        end
    end

    assign func_en_o  = func_en_q;
    assign rise_sel_o = rise_sel_q;
    assign ien_o      = ien_q;

endmodule

// File: rtl/eirq_channel.sv
// Module: eirq_channel
// One interrupt channel. It gates the synchronised pin with the function
// enable (disabled reads high), detects the selected edge on the gated
// level, and latches a request flag. A set wins over a clear in the same
// cycle. Assumes pin_sync_i is already in the clock domain.
module eirq_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync_i,
    input  logic func_en_i,
    input  logic rise_sel_i,
    input  logic clr_req_i,
    output logic flag_o,
    output logic gated_o,
    output logic gated_prev_o
);

    logic gated;
    logic gated_prev_q;
    logic edge_hit;
    logic flag_q;

    assign gated = func_en_i ? pin_sync_i : 1'b1;

    // Keep the gated level of the previous cycle for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gated_prev_q <= 1'b1;
        end else begin
            gated_prev_q <= gated;
        end
    end

    // Pick the edge polarity chosen by the edge-select bit.
    always_comb begin
        if (rise_sel_i) begin
            edge_hit = gated & ~gated_prev_q;
        end else begin
            edge_hit = ~gated & gated_prev_q;
        end
    end

    // Latch the request flag; a detected edge overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (edge_hit) begin
            flag_q <= 1'b1;
        end else if (clr_req_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o       = flag_q;
    assign gated_o      = gated;
    assign gated_prev_o = gated_prev_q;

endmodule

// File: rtl/ext_irq_edge_ctrl.sv
// Module: ext_irq_edge_ctrl
// Top level of the external interrupt pin edge controller. It instantiates
// the register block and one synchroniser plus channel per pin, and ORs
// the enabled flags into irq_o. Assumes synchronous active-low reset and
// pins that idle high.
module ext_irq_edge_ctrl #(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_pin_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    output logic [NUM_CH-1:0] req_flag_o,
    output logic              irq_o
);

    logic [NUM_CH-1:0] func_en;
    logic [NUM_CH-1:0] rise_sel;
    logic [NUM_CH-1:0] ien;
    logic [NUM_CH-1:0] clr_req;
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] flags;
    logic [NUM_CH-1:0] gated_lvl;
    logic [NUM_CH-1:0] gated_prv;

    eirq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .func_en_o  (func_en),
        .rise_sel_o (rise_sel),
        .ien_o      (ien),
        .clr_req_o  (clr_req)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (irq_pin_i[ch]),
            .q_o   (pin_sync[ch])
        );

        eirq_channel u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .pin_sync_i   (pin_sync[ch]),
            .func_en_i    (func_en[ch]),
            .rise_sel_i   (rise_sel[ch]),
            .clr_req_i    (clr_req[ch]),
            .flag_o       (flags[ch]),
            .gated_o      (gated_lvl[ch]),
            .gated_prev_o (gated_prv[ch])
        );
    end

    assign req_flag_o = flags;
    assign irq_o      = |(flags & ien);

endmodule

// File: rtl/ext_irq_edge_ctrl_chk.sv
// Module: ext_irq_edge_ctrl_chk
// Property checker bound to ext_irq_edge_ctrl. It watches the write port,
// the flags, the combined output and the per-channel gated levels.
module ext_irq_edge_ctrl_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [NUM_CH-1:0] wr_data,
    input logic [NUM_CH-1:0] req_flag,
    input logic              irq,
    input logic [NUM_CH-1:0] gated,
    input logic [NUM_CH-1:0] gated_prev
);

    // R10: the combined output needs at least one set flag.
    p_irq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|req_flag));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_prop
        // R8: a flag with no clear write on it stays set.
        p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
            req_flag[ch] && !(wr_en && (wr_addr == 2'd3) && !wr_data[ch])
            |=> req_flag[ch]);

        // R9: a clear directly after a mode write leaves the flag set.
        p_clear_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && (wr_addr == 2'd0)) && wr_en && (wr_addr == 2'd3)
            && req_flag[ch] |=> req_flag[ch]);

        // R3: a flag only rises after the gated level changed.
        p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(req_flag[ch]) |-> $past(gated[ch] != gated_prev[ch]));
    end

endmodule

bind ext_irq_edge_ctrl ext_irq_edge_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .req_flag   (req_flag_o),
    .irq        (irq_o),
    .gated      (gated_lvl),
    .gated_prev (gated_prv)
);

// File: tb/ext_irq_edge_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_edge_ctrl_tb;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pins = '1;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_addr = '0;
    logic [NCH-1:0] wr_data = '0;
    logic [NCH-1:0] flags;
    logic           irq;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    ext_irq_edge_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pin_i  (pins),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .req_flag_o (flags),
        .irq_o      (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 flags", 8'(flags), 8'h0);
        chk("R1 irq", 8'(irq), 8'h0);

        // R12: pins toggle with function disabled, nothing latches
        pins = '0; idle(5); pins = '1; idle(5);
        chk("R12 masked toggle", 8'(flags), 8'h0);

        // Sweep mode rewrites: channel, edge select, pin level, direction (R5 R6 R7)
        for (int c = 0; c < NCH; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int l = 0; l < 2; l++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic [NCH-1:0] bit_c;
                        logic           exp;
                        bit_c = NCH'(1) << c;
                        wr(2'd1, s ? bit_c : '0);
                        wr(2'd0, d ? bit_c : '0);
                        pins[c] = l[0];
                        idle(5);
                        wr(2'd3, '0);
                        chk("R8 clear before case", 8'(flags), 8'h0);
                        wr(2'd0, d ? '0 : bit_c);
                        idle(3);
                        exp = !l[0] && ((d == 0 && s == 0) || (d == 1 && s == 1));
                        if (l == 1)      chk("R7 high pin no set", 8'(flags), 8'h0);
                        else if (d == 0) chk("R5 enable rise", 8'(flags), exp ? 8'(bit_c) : 8'h0);
                        else             chk("R6 enable fall", 8'(flags), exp ? 8'(bit_c) : 8'h0);
                        pins[c] = 1'b1;
                        wr(2'd0, '0);
                        idle(4);
                        wr(2'd3, '0);
                    end
                end
            end
        end

        // R3 / R4: pin edges with exact latency
        wr(2'd1, 3'b010);
        wr(2'd0, 3'b111);
        idle(4);
        wr(2'd3, '0);
        pins = 3'b000;            // falls: ch1,ch3 (sel 0) set; ch2 (sel 1) not
        idle(2);
        chk("R3 latency not yet", 8'(flags), 8'h0);
        idle(1);
        chk("R3 falling sets, R4 wrong polarity", 8'(flags), 8'h05);
        pins = 3'b111;            // rises: ch2 set
        idle(3);
        chk("R4 rising sets", 8'(flags), 8'h07);

        // R2: writing 1 to flags keeps them; writing 1 to clear flags sets nothing
        wr(2'd3, 3'b111);
        chk("R2 write one keeps", 8'(flags), 8'h07);
        wr(2'd3, 3'b101);
        chk("R2 R8 clear bit2 only", 8'(flags), 8'h05);
        wr(2'd3, 3'b111);
        chk("R2 write one no set", 8'(flags), 8'h05);

        // R10: all enable masks against two flag patterns, flags set with enables 0
        wr(2'd3, '0);
        wr(2'd1, '0);
        pins = 3'b000;
        idle(4);
        chk("R10 flags set while disabled", 8'(flags), 8'h07);
        for (int e = 0; e < 8; e++) begin
            wr(2'd2, 3'(e));
            chk("R10 irq all flags", 8'(irq), (e != 0) ? 8'h1 : 8'h0);
        end
        wr(2'd3, 3'b101);
        for (int e = 0; e < 8; e++) begin
            wr(2'd2, 3'(e));
            chk("R10 irq partial flags", 8'(irq), ((e & 5) != 0) ? 8'h1 : 8'h0);
        end
        wr(2'd2, '0);

        // R9: clear in the slot right after a mode write is dropped
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 3'b111;
        @(negedge clk);
        wr_addr = 2'd3; wr_data = 3'b000;
        @(negedge clk);
        wr_en = 1'b0;
        idle(1);
        chk("R9 blocked clear", 8'(flags), 8'h05);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 3'b111;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 3'b000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 second slot clear", 8'(flags), 8'h00);

        // R11: set and effective clear on the same edge
        pins[0] = 1'b1;
        idle(4);
        pins[0] = 1'b0;           // captured at next posedge a, set at a+2
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 3'b000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 set beats clear", 8'(flags), 8'h01);
        wr(2'd3, '0);
        chk("R8 later clear works", 8'(flags), 8'h00);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule